// File: doc/BRIEF.md
# Chassis Slot Discovery and Task Assignment Engine

This block walks a 16-slot controller chassis once per start request and works out which service task each installed controller will own. It first seeds every slot entry with a placeholder address and clocks those entries serially out to the controllers. It then polls each slot for its identification word. Each slot is searched against a small device ROM, and the slot entry is replaced by the ROM's init address and task number. The final task codes are clocked serially back out, and the resolved list is presented one slot per cycle for the init sequencer that follows.

A task bitmask makes the search aware of ownership. If the ROM entry that matches a slot's ID names a task already granted to an earlier slot, the search does not stop there. It moves further down the ROM, so a second copy of the same board picks up the next entry written for that ID and gets a different task. The flow is one state machine with these states: IDLE (waiting), PROBE (placeholder shift), READ (ID poll), FETCH (ROM address presented), MATCH (ROM word judged), ASSIGN (task shift), EMIT (list output) and DONE (one-cycle completion).

The transitions are as follows. IDLE goes to PROBE on `start`. PROBE goes to READ after slot 0's last bit. READ goes to FETCH after slot 15. FETCH always goes to MATCH. MATCH goes back to FETCH while the search continues or the next slot begins, and goes to ASSIGN once slot 15 is resolved. ASSIGN goes to EMIT after slot 0's last bit. EMIT goes to DONE after slot 0. DONE always returns to IDLE.

Top module: `slot_enum`

## Requirements
- R1: After reset, and whenever the engine is idle, `busy`, `done`, `shift_strobe`, `out_valid` and `id_rd` are all low.
- R2: A `start` seen while idle raises `busy` on the next cycle. `busy` stays high through a single-cycle `done` pulse that follows the last emitted entry, and it is low on the cycle after `done`.
- R3: The placeholder shift issues 64 strobes. Slots go from 15 down to 0, and each slot sends the low 4 bits of (slot << 12) + 3, least significant bit first, with each bit inverted on `shift_data`. Every slot therefore sends 0,0,1,1.
- R4: During the ID poll, `id_rd` is high for 16 consecutive cycles while `id_sel` steps from 0 up to 15. Only `id_data[15:8]` takes part in matching; the low byte has no effect.
- R5: A ROM word is laid out as key [23:16], init address [15:4] and task [3:0]. The data for `rom_addr` is expected on `rom_data` one cycle after the address is presented.
- R6: Slots are resolved in order 0 to 15. Each search starts at ROM address 0, and the first entry whose key equals the slot's ID byte and whose task is still free is granted to that slot.
- R7: A ROM word that is entirely zero ends the search. The slot then gets task 15 and init address 0.
- R8: A key match whose task is already granted is skipped and the search continues, so identical boards receive distinct tasks from repeated ROM entries.
- R9: If the search reaches the last ROM address (31) without a grant and without meeting a zero word, the slot gets task 15 and init address 0.
- R10: After all slots are resolved, a second run of 64 strobes sends each slot's 4-bit task, slots 15 down to 0, LSB first and inverted.
- R11: The list is emitted with `out_valid` high for 16 consecutive cycles, slots 15 down to 0, carrying init address and task. `out_noinit` is high exactly when the init address is zero.
- R12: The task bitmask is cleared on every start, so one run's grants do not constrain the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an enumeration pass (taken only when idle) |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| shift_data | output | 1 | Inverted serial bit, valid while shift_strobe is high |
| shift_strobe | output | 1 | One pulse per serial bit |
| id_rd | output | 1 | ID poll in progress; id_data is sampled this cycle |
| id_sel | output | 4 | Slot whose ID is being polled |
| id_data | input | 16 | ID word of the selected slot (same cycle) |
| rom_addr | output | 5 | Device ROM address |
| rom_data | input | 24 | Device ROM word, one cycle after rom_addr |
| out_valid | output | 1 | Resolved list entry valid |
| out_slot | output | 4 | Slot of the current list entry |
| out_init | output | 12 | Init address of the entry |
| out_task | output | 4 | Task of the entry |
| out_noinit | output | 1 | Entry needs no initialization routine |

## Verification
The hardest situation to reach is a ROM walk that passes a key match because the task is already owned and then finds a later free entry. The same walk must also handle the case where it runs out at a zero word or at address 31. The bench places several identical boards and one board whose matching entry's task was taken by a different ID. It also runs a full 32-entry ROM with no terminator whose only match sits in the last word. Randomized passes draw IDs and ROM keys from a small shared pool, so collisions happen often, and they reuse the engine back to back to show that the bitmask starts clean.

// File: rtl/slot_enum_pkg.sv
package slot_enum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_READ,
        ST_FETCH,
        ST_MATCH,
        ST_ASSIGN,
        ST_EMIT,
        ST_DONE
    } enum_state_t;

endpackage

// File: rtl/slot_enum_table.sv
module slot_enum_table #(
    parameter int SLOTS  = 16,
    parameter int ENT_W  = 16,
    parameter int TASK_W = 4,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_dummy,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic [ENT_W-1:0]  wr_data,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [ENT_W-1:0]  rd_data
);
    localparam int SLOT_SHIFT = ENT_W - TASK_W;

    logic [ENT_W-1:0] ent_q [SLOTS];

    // placeholder per slot: (slot << SLOT_SHIFT) + 3
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) ent_q[i] <= '0;
        end else if (load_dummy) begin
            for (int i = 0; i < SLOTS; i++)
                ent_q[i] <= (ENT_W'(i) << SLOT_SHIFT) + ENT_W'(3);
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/slot_enum_taskmask.sv
module slot_enum_taskmask #(
    parameter int TASK_W = 4,
    parameter int TASKS  = 1 << TASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_en,
    input  logic [TASK_W-1:0] set_idx,
    input  logic [TASK_W-1:0] test_idx,
    output logic              taken
);
    logic [TASKS-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask_q <= '0;
        else if (clr)    mask_q <= '0;
        else if (set_en) mask_q[set_idx] <= 1'b1;
    end

    assign taken = mask_q[test_idx];

endmodule

// File: rtl/slot_enum.sv
module slot_enum
    import slot_enum_pkg::*;
#(
    parameter int SLOTS     = 16,
    parameter int ID_W      = 16,
    parameter int KEY_W     = 8,
    parameter int INIT_W    = 12,
    parameter int TASK_W    = 4,
    parameter int TAB_DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         busy,
    output logic                         done,
    output logic                         shift_data,
    output logic                         shift_strobe,
    output logic                         id_rd,
    output logic [$clog2(SLOTS)-1:0]     id_sel,
    input  logic [ID_W-1:0]              id_data,
    output logic [$clog2(TAB_DEPTH)-1:0] rom_addr,
    input  logic [KEY_W+INIT_W+TASK_W-1:0] rom_data,
    output logic                         out_valid,
    output logic [$clog2(SLOTS)-1:0]     out_slot,
    output logic [INIT_W-1:0]            out_init,
    output logic [TASK_W-1:0]            out_task,
    output logic                         out_noinit
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int ADR_W  = $clog2(TAB_DEPTH);
    localparam int BIT_W  = $clog2(TASK_W);
    localparam int ENT_W  = INIT_W + TASK_W;
    localparam int ROM_W  = KEY_W + ENT_W;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [ADR_W-1:0]  ADR_LAST  = ADR_W'(TAB_DEPTH - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(TASK_W - 1);
    localparam logic [ENT_W-1:0]  UNUSED_ENT = {{INIT_W{1'b0}}, {TASK_W{1'b1}}};

    enum_state_t       st_q, st_d;
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bitc_q;
    logic [ADR_W-1:0]  idx_q;
    logic [KEY_W-1:0]  id_key_q [SLOTS];

    logic [KEY_W-1:0]  ent_key;
    logic [INIT_W-1:0] ent_init;
    logic [TASK_W-1:0] ent_task;
    logic              ent_zero, ent_hit, task_taken;
    logic              claim, give_up, slot_end, bit_last, go;
    logic [ENT_W-1:0]  tab_rd, tab_wr;
    logic [TASK_W-1:0] nib;
    logic              unused_id_lo;

    assign unused_id_lo = ^id_data[ID_W-KEY_W-1:0];

    // ROM word decode and search decisions
    always_comb begin
        ent_key  = rom_data[ROM_W-1 -: KEY_W];
        ent_init = rom_data[ENT_W-1:TASK_W];
        ent_task = rom_data[TASK_W-1:0];
        ent_zero = (rom_data == '0);
        ent_hit  = (ent_key == id_key_q[slot_q]);
        claim    = (st_q == ST_MATCH) && !ent_zero && ent_hit && !task_taken;
        give_up  = (st_q == ST_MATCH) && !claim && (ent_zero || idx_q == ADR_LAST);
        slot_end = claim || give_up;
        bit_last = (bitc_q == BIT_LAST);
        go       = (st_q == ST_IDLE) && start;
        tab_wr   = claim ? {ent_init, ent_task} : UNUSED_ENT;
    end

    slot_enum_table #(.SLOTS(SLOTS), .ENT_W(ENT_W), .TASK_W(TASK_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_dummy(go),
        .wr_en     (slot_end),
        .wr_idx    (slot_q),
        .wr_data   (tab_wr),
        .rd_idx    (slot_q),
        .rd_data   (tab_rd)
    );

    slot_enum_taskmask #(.TASK_W(TASK_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go),
        .set_en  (claim),
        .set_idx (ent_task),
        .test_idx(ent_task),
        .taken   (task_taken)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_PROBE;
            ST_PROBE:  if (bit_last && slot_q == '0) st_d = ST_READ;
            ST_READ:   if (slot_q == SLOT_LAST) st_d = ST_FETCH;
            ST_FETCH:  st_d = ST_MATCH;
            ST_MATCH:  st_d = (slot_end && slot_q == SLOT_LAST) ? ST_ASSIGN : ST_FETCH;
            ST_ASSIGN: if (bit_last && slot_q == '0) st_d = ST_EMIT;
            ST_EMIT:   if (slot_q == '0) st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            slot_q <= '0;
            bitc_q <= '0;
            idx_q  <= '0;
            for (int i = 0; i < SLOTS; i++) id_key_q[i] <= '0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    slot_q <= SLOT_LAST;
                    bitc_q <= '0;
                    idx_q  <= '0;
                end
                ST_PROBE, ST_ASSIGN: begin
                    bitc_q <= bit_last ? '0 : bitc_q + BIT_W'(1);
                    if (bit_last) begin
                        if (slot_q == '0)
                            slot_q <= (st_q == ST_ASSIGN) ? SLOT_LAST : '0;
                        else
                            slot_q <= slot_q - SLOT_W'(1);
                    end
                end
                ST_READ: begin
                    id_key_q[slot_q] <= id_data[ID_W-1 -: KEY_W];
                    slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + SLOT_W'(1);
                end
                ST_FETCH: ;
                ST_MATCH: begin
                    if (slot_end) begin
                        idx_q  <= '0;
                        bitc_q <= '0;
                        if (slot_q != SLOT_LAST) slot_q <= slot_q + SLOT_W'(1);
                    end else begin
                        idx_q <= idx_q + ADR_W'(1);
                    end
                end
                ST_EMIT: slot_q <= slot_q - SLOT_W'(1);
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        nib          = tab_rd[TASK_W-1:0];
        busy         = (st_q != ST_IDLE);
        done         = (st_q == ST_DONE);
        shift_strobe = (st_q == ST_PROBE) || (st_q == ST_ASSIGN);
        shift_data   = shift_strobe && !nib[bitc_q];
        id_rd        = (st_q == ST_READ);
        id_sel       = slot_q;
        rom_addr     = idx_q;
        out_valid    = (st_q == ST_EMIT);
        out_slot     = slot_q;
        out_init     = tab_rd[ENT_W-1:TASK_W];
        out_task     = tab_rd[TASK_W-1:0];
        out_noinit   = out_valid && (tab_rd[ENT_W-1:TASK_W] == '0);
    end

endmodule

// File: rtl/slot_enum_chk.sv
module slot_enum_chk #(
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              shift_strobe,
    input logic              id_rd,
    input logic [SLOT_W-1:0] id_sel,
    input logic              out_valid,
    input logic [SLOT_W-1:0] out_slot
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!shift_strobe && !out_valid && !id_rd && !done));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_strobe |-> (!out_valid && !id_rd && !done));

    // R4
    poll_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && $past(id_rd)) |-> (id_sel == $past(id_sel) + SLOT_W'(1)));

    // R11
    emit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_slot == $past(out_slot) - SLOT_W'(1)));

endmodule

bind slot_enum slot_enum_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .shift_strobe(shift_strobe),
    .id_rd       (id_rd),
    .id_sel      (id_sel),
    .out_valid   (out_valid),
    .out_slot    (out_slot)
);

// File: tb/slot_enum_bench.sv
`timescale 1ns/1ps
module slot_enum_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, shift_data, shift_strobe, id_rd;
    logic [3:0]  id_sel;
    logic [15:0] id_data;
    logic [4:0]  rom_addr;
    logic [23:0] rom_q = '0;
    logic        out_valid, out_noinit;
    logic [3:0]  out_slot, out_task;
    logic [11:0] out_init;

    logic [23:0] rom_mem [32];
    logic [15:0] ids [16];
    logic [11:0] exp_init [16];
    logic [3:0]  exp_task [16];

    logic        sh_bits [256];
    int          sh_cnt = 0;
    logic [3:0]  em_slot [32];
    logic [11:0] em_init [32];
    logic [3:0]  em_task [32];
    logic        em_noi  [32];
    int          em_cnt = 0;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    slot_enum u_slot_enum (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .shift_data(shift_data), .shift_strobe(shift_strobe),
        .id_rd(id_rd), .id_sel(id_sel), .id_data(id_data),
        .rom_addr(rom_addr), .rom_data(rom_q),
        .out_valid(out_valid), .out_slot(out_slot), .out_init(out_init),
        .out_task(out_task), .out_noinit(out_noinit)
    );

    // R4: ID port answers combinationally; R5: ROM answers one cycle later
    assign id_data = ids[id_sel];
    always @(posedge clk) rom_q <= rom_mem[rom_addr];

    always @(negedge clk) begin
        if (shift_strobe && sh_cnt < 256) begin
            sh_bits[sh_cnt] = shift_data;
            sh_cnt++;
        end
        if (out_valid && em_cnt < 32) begin
            em_slot[em_cnt] = out_slot;
            em_init[em_cnt] = out_init;
            em_task[em_cnt] = out_task;
            em_noi[em_cnt]  = out_noinit;
            em_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model();
        logic [15:0] m;
        m = '0;
        for (int s = 0; s < 16; s++) begin
            exp_task[s] = 4'hF;
            exp_init[s] = '0;
            for (int i = 0; i < 32; i++) begin
                if (rom_mem[i] == '0) break;
                if (rom_mem[i][23:16] == ids[s][15:8] && !m[rom_mem[i][3:0]]) begin
                    m[rom_mem[i][3:0]] = 1'b1;
                    exp_task[s] = rom_mem[i][3:0];
                    exp_init[s] = rom_mem[i][15:4];
                    break;
                end
            end
        end
    endtask

    task automatic run_case(input string req);
        int cyc;
        model();
        sh_cnt = 0;
        em_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R2", "done reached", int'(done), 1);
        chk(busy == 1'b1, "R2", "busy during done", int'(busy), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R2", "busy after done", int'(busy), 0);
        chk(done == 1'b0, "R2", "done single cycle", int'(done), 0);
        chk(sh_cnt == 128, "R3", "strobe count", sh_cnt, 128);
        chk(em_cnt == 16, "R11", "emit count", em_cnt, 16);
        for (int i = 0; i < 64 && i < sh_cnt; i++) begin
            int s = 15 - i / 4;
            int b = i % 4;
            logic [15:0] dv = (16'(s) << 12) + 16'd3;
            chk(sh_bits[i] == !dv[b], "R3", "probe bit", int'(sh_bits[i]), int'(!dv[b]));
        end
        for (int i = 64; i < 128 && i < sh_cnt; i++) begin
            int s = 15 - (i - 64) / 4;
            int b = (i - 64) % 4;
            chk(sh_bits[i] == !exp_task[s][b], "R10", "task bit",
                int'(sh_bits[i]), int'(!exp_task[s][b]));
        end
        for (int k = 0; k < 16 && k < em_cnt; k++) begin
            int s = 15 - k;
            chk(em_slot[k] == 4'(s), "R11", "emit slot", int'(em_slot[k]), s);
            chk(em_task[k] == exp_task[s], req, "slot task", int'(em_task[k]), int'(exp_task[s]));
            chk(em_init[k] == exp_init[s], req, "slot init", int'(em_init[k]), int'(exp_init[s]));
            chk(em_noi[k] == (exp_init[s] == '0), "R11", "noinit flag",
                int'(em_noi[k]), int'(exp_init[s] == '0));
        end
    endtask

    function automatic logic [7:0] pool_key();
        case ($urandom % 5)
            0: return 8'h21;
            1: return 8'h42;
            2: return 8'h63;
            3: return 8'h84;
            default: return 8'hA5;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) rom_mem[i] = '0;
        for (int i = 0; i < 16; i++) ids[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy", int'(busy), 0);
        chk(done == 0, "R1", "done", int'(done), 0);
        chk(shift_strobe == 0, "R1", "strobe", int'(shift_strobe), 0);
        chk(out_valid == 0, "R1", "out_valid", int'(out_valid), 0);
        chk(id_rd == 0, "R1", "id_rd", int'(id_rd), 0);

        // R7: empty ROM, every slot unused
        for (int i = 0; i < 16; i++) ids[i] = 16'(($urandom % 250 + 1) << 8) | 16'($urandom % 256);
        run_case("R7");

        // R8 / R6: identical boards and a key hit on a taken task
        for (int i = 0; i < 16; i++) ids[i] = 16'h00AB;
        ids[0] = 16'hA011; ids[1] = 16'hA0FE; ids[2] = 16'hA033; ids[5] = 16'hB044;
        for (int i = 0; i < 32; i++) rom_mem[i] = '0;
        rom_mem[0] = {8'hA0, 12'h100, 4'd2};
        rom_mem[1] = {8'hB0, 12'h200, 4'd2};
        rom_mem[2] = {8'hA0, 12'h104, 4'd3};
        rom_mem[3] = {8'hB0, 12'h208, 4'd7};
        run_case("R8");

        // R9: full ROM without terminator; last word matches with zero init
        for (int i = 0; i < 16; i++) ids[i] = 16'h11C3;
        ids[3] = 16'h7700; ids[8] = 16'h6601;
        for (int i = 0; i < 31; i++) rom_mem[i] = {8'h66, 12'(i + 1), 4'(i % 16)};
        rom_mem[31] = {8'h77, 12'h000, 4'd9};
        run_case("R9");

        // R4: same high bytes, different low bytes -> same result
        for (int i = 0; i < 16; i++) ids[i][7:0] = 8'($urandom);
        run_case("R4");

        // R6 / R12: random back-to-back passes from a small key pool
        for (int t = 0; t < 24; t++) begin
            int n = $urandom_range(1, 31);
            for (int i = 0; i < 16; i++) ids[i] = {pool_key(), 8'($urandom)};
            for (int i = 0; i < 32; i++) begin
                if (i < n)
                    rom_mem[i] = {pool_key(), (($urandom % 4) == 0) ? 12'h000 : 12'($urandom), 4'($urandom)};
                else
                    rom_mem[i] = '0;
            end
            run_case((t % 2 == 0) ? "R6" : "R12");
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule